// File: doc/BRIEF.md
# Windowed Link Utilization Sampler

This block sits beside one mesh router and measures how busy each of its five ports is. Every port raises a one-cycle strobe for each flit it moves. The block counts those strobes over a sampling window of programmable length, 80 cycles by default. At the last cycle of each window it turns every count into an 8-bit fraction of full load. It then presents all five fractions together as one valid-qualified report, which a downstream fault-detection engine uses.

If the report path is blocked when a report becomes due, the five averages are dropped. Every field carries a programmable sentinel value instead (50 by default), and a flag marks the report as a blocked-buffer indication. A report is held until the path accepts it. A newer report replaces one that is still waiting. A change in traffic that starts part-way through a window only shows up at the next window boundary. The sampling delay is therefore the number of cycles left in the window.

Top module: `link_util_sampler`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `rpt_valid` is 0. All port counts and the window position start at zero.
- R2: Each port's count rises by one in every non-boundary cycle in which its strobe is high. The count saturates at the effective window length.
- R3: The effective window length W is `cfg_window`, and a value of 0 acts as 1. The boundary is the W-th cycle of each window, and the first boundary is the W-th clock edge after reset release. `rpt_valid` is high in the cycle after every boundary.
- R4: All five counts clear together at a boundary. A strobe that is high in the boundary cycle is counted as the first cycle of the new window.
- R5: If `out_ready` is high in the boundary cycle, the report for port p sits at `rpt_data[8p+7:8p]`. Its value is floor(count x 255 / W), using the count reached before the boundary cycle's strobe, and `rpt_sentinel` is 0.
- R6: If `out_ready` is low in the boundary cycle, every 8-bit field of the report equals `cfg_sentinel` and `rpt_sentinel` is 1.
- R7: A valid report keeps its data and flag unchanged while `out_ready` is low. It is accepted in a cycle where `rpt_valid` and `out_ready` are both high. `rpt_valid` is 0 in the next cycle unless that cycle follows a boundary.
- R8: A boundary that comes while an older report is still pending overwrites it with the new report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_strobe | input | 5 | One bit per port, high for each flit moved in that cycle |
| cfg_window | input | 8 | Window length in cycles (0 acts as 1) |
| cfg_sentinel | input | 8 | Value placed in every field of a blocked report |
| out_ready | input | 1 | High when the report path can take a report |
| rpt_valid | output | 1 | A report is presented |
| rpt_sentinel | output | 1 | The presented report holds sentinel values |
| rpt_data | output | 40 | Five 8-bit utilization fields, port p at bits 8p+7:8p |

## Verification
A report is due one clock edge after a boundary cycle. The first boundary is the W-th edge after reset release, so the first report is seen after edge W. An acceptance clears `rpt_valid` one edge after the accepting cycle. The bench drives strobes and `out_ready` on the falling edge. In the same step it advances an arithmetic model of the window position, the counts and the pending report by one cycle. It compares the outputs at the next falling edge, after exactly one rising edge has passed. The sweeps cover full, idle, mixed and boundary-only traffic, random back-pressure, long blocking that forces overwrites, a zero window and the default 80/50 setting.

// File: rtl/lus_pkg.sv
package lus_pkg;
    localparam int NPORT_DEF = 5;
    localparam int CNT_W_DEF = 8;
    localparam int VAL_W_DEF = 8;

    typedef enum logic {
        RPT_AVG  = 1'b0,
        RPT_SENT = 1'b1
    } rpt_kind_e;
endpackage

// File: rtl/lus_window_timer.sv
module lus_window_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_window,
    output logic [CNT_W-1:0] eff_win,
    output logic             boundary
);
    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        eff_win  = (cfg_window == '0) ? CNT_W'(1) : cfg_window;
        boundary = (st_q.pos >= eff_win - CNT_W'(1));
        if (boundary) st_d.pos = '0;
        else          st_d.pos = st_q.pos + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_q.pos < $past(eff_win));
endmodule

// File: rtl/lus_port_counter.sv
module lus_port_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             boundary,
    input  logic [CNT_W-1:0] eff_win,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pc_s;

    pc_s          st_d, st_q;
    logic [CNT_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, strobe};
        if (boundary)
            st_d.cnt = {{(CNT_W-1){1'b0}}, strobe};
        else if (sum > {1'b0, eff_win})
            st_d.cnt = eff_win;
        else
            st_d.cnt = sum[CNT_W-1:0];
        count = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_q.cnt <= $past(eff_win));

    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> st_q.cnt <= CNT_W'(1));
endmodule

// File: rtl/lus_scaler.sv
module lus_scaler #(
    parameter int CNT_W = 8,
    parameter int VAL_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] eff_win,
    output logic [VAL_W-1:0] avg
);
    localparam int PROD_W = CNT_W + VAL_W;
    localparam logic [PROD_W-1:0] FULL = PROD_W'((1 << VAL_W) - 1);

    logic [CNT_W-1:0]  clamped;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        clamped = (count > eff_win) ? eff_win : count;
        prod    = PROD_W'(clamped) * FULL;
        quot    = prod / PROD_W'(eff_win);
        avg     = quot[VAL_W-1:0];
    end
endmodule

// File: rtl/link_util_sampler.sv
module link_util_sampler
    import lus_pkg::*;
#(
    parameter int NPORT = NPORT_DEF,
    parameter int CNT_W = CNT_W_DEF,
    parameter int VAL_W = VAL_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT-1:0]       flit_strobe,
    input  logic [CNT_W-1:0]       cfg_window,
    input  logic [VAL_W-1:0]       cfg_sentinel,
    input  logic                   out_ready,
    output logic                   rpt_valid,
    output logic                   rpt_sentinel,
    output logic [NPORT*VAL_W-1:0] rpt_data
);
    localparam int DATA_W = NPORT * VAL_W;

    typedef struct packed {
        logic              valid;
        rpt_kind_e         kind;
        logic [DATA_W-1:0] data;
    } rpt_s;

    rpt_s              rpt_d, rpt_q;
    logic [CNT_W-1:0]  eff_win;
    logic              boundary;
    logic [CNT_W-1:0]  counts [NPORT];
    logic [VAL_W-1:0]  avgs   [NPORT];

    lus_window_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_window (cfg_window),
        .eff_win    (eff_win),
        .boundary   (boundary)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        lus_port_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe   (flit_strobe[p]),
            .boundary (boundary),
            .eff_win  (eff_win),
            .count    (counts[p])
        );
        lus_scaler #(.CNT_W(CNT_W), .VAL_W(VAL_W)) u_scale (
            .count   (counts[p]),
            .eff_win (eff_win),
            .avg     (avgs[p])
        );
    end

    always_comb begin
        rpt_d = rpt_q;
        if (rpt_q.valid && out_ready)
            rpt_d.valid = 1'b0;
        if (boundary) begin
            rpt_d.valid = 1'b1;
            rpt_d.kind  = out_ready ? RPT_AVG : RPT_SENT;
            for (int p = 0; p < NPORT; p++)
                rpt_d.data[p*VAL_W +: VAL_W] = out_ready ? avgs[p] : cfg_sentinel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rpt_q <= '0;
        else        rpt_q <= rpt_d;
    end

    assign rpt_valid    = rpt_q.valid;
    assign rpt_sentinel = (rpt_q.kind == RPT_SENT);
    assign rpt_data     = rpt_q.data;

    // R7
    hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid && !out_ready |=> rpt_valid);

    // R7
    stable_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid && !out_ready && !boundary |=> $stable(rpt_data) && $stable(rpt_sentinel));

    // R3
    report_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> rpt_valid);

    // R6
    sentinel_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && !out_ready |=> rpt_sentinel);

    // R5
    avg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && out_ready |=> !rpt_sentinel);
endmodule

// File: tb/tb_link_util_sampler.sv
module tb_link_util_sampler;
    localparam int NP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] flit_strobe = '0;
    logic [7:0]    cfg_window = 8'd8;
    logic [7:0]    cfg_sentinel = 8'd50;
    logic          out_ready = 1'b1;
    logic          rpt_valid;
    logic          rpt_sentinel;
    logic [NP*8-1:0] rpt_data;

    int total = 0;
    int bad   = 0;

    int m_cnt [NP];
    int m_data[NP];
    int m_w, m_valid, m_sent;

    link_util_sampler dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .flit_strobe  (flit_strobe),
        .cfg_window   (cfg_window),
        .cfg_sentinel (cfg_sentinel),
        .out_ready    (out_ready),
        .rpt_valid    (rpt_valid),
        .rpt_sentinel (rpt_sentinel),
        .rpt_data     (rpt_data)
    );

    always #4 clk = ~clk;

    function automatic int eff();
        return (cfg_window == 8'd0) ? 1 : int'(cfg_window);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input int win, input int sent);
        @(negedge clk);
        rst_n        = 1'b0;
        cfg_window   = 8'(win);
        cfg_sentinel = 8'(sent);
        flit_strobe  = '0;
        out_ready    = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "rpt_valid in reset", int'(rpt_valid), 0);
        rst_n = 1'b1;
        m_w = 0; m_valid = 0; m_sent = 0;
        for (int p = 0; p < NP; p++) begin m_cnt[p] = 0; m_data[p] = 0; end
    endtask

    // Drive one cycle at a falling edge, advance the model, compare at the next falling edge.
    task automatic step(input string ph, input logic [NP-1:0] s, input logic r);
        int e;
        e = eff();
        flit_strobe = s;
        out_ready   = r;
        if (m_w >= e - 1) begin
            m_valid = 1;
            m_sent  = r ? 0 : 1;
            for (int p = 0; p < NP; p++) begin
                m_data[p] = r ? (m_cnt[p] * 255) / e : int'(cfg_sentinel);
                m_cnt[p]  = int'(s[p]);
            end
            m_w = 0;
        end else begin
            if (m_valid != 0 && r) m_valid = 0;
            for (int p = 0; p < NP; p++) begin
                m_cnt[p] = m_cnt[p] + int'(s[p]);
                if (m_cnt[p] > e) m_cnt[p] = e;
            end
            m_w++;
        end
        @(negedge clk);
        check({ph, " R3"}, "rpt_valid", int'(rpt_valid), m_valid);
        if (m_valid != 0) begin
            check({ph, " R6"}, "rpt_sentinel", int'(rpt_sentinel), m_sent);
            for (int p = 0; p < NP; p++)
                check({ph, m_sent != 0 ? " R6" : " R5"}, $sformatf("field %0d", p),
                      int'(rpt_data[p*8 +: 8]), m_data[p]);
        end
    endtask

    function automatic logic [NP-1:0] mix(input int t);
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++)
            v[p] = ((((t * 7) + (p * 13)) ^ (t >> 1)) % (p + 2)) == 0;
        return v;
    endfunction

    function automatic logic rdy(input int t);
        return (((t * 5) ^ (t >> 2)) % 3) != 0;
    endfunction

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset and first report timing (R3)
        do_reset(8, 50);
        for (int t = 0; t < 40; t++) step("R2 full load", '1, 1'b1);
        for (int t = 0; t < 24; t++) step("R5 idle", '0, 1'b1);
        for (int t = 0; t < 80; t++) step("R5 mixed", mix(t), 1'b1);

        // R4: strobes only in boundary cycles land in the new window
        do_reset(4, 50);
        for (int t = 0; t < 40; t++)
            step("R4 edge strobes", (m_w >= eff() - 1) ? '1 : '0, 1'b1);

        // R6 R7: back-pressure
        do_reset(6, 77);
        for (int t = 0; t < 150; t++) step("R7 backpressure", mix(t + 3), rdy(t));

        // R8: long blocking, overwrite of pending reports
        do_reset(5, 9);
        for (int t = 0; t < 22; t++) step("R8 overwrite", mix(t), 1'b0);
        for (int t = 0; t < 12; t++) step("R8 drain", mix(t), 1'b1);

        // R3: zero window acts as one cycle
        do_reset(0, 50);
        for (int t = 0; t < 16; t++) step("R3 zero window", mix(t), 1'b1);

        // R6: default 80-cycle window with sentinel 50
        do_reset(80, 50);
        for (int t = 0; t < 170; t++) step("R6 default blocked", mix(t), 1'b0);
        for (int t = 0; t < 250; t++) step("R5 default", mix(t + 11), rdy(t + 1));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule